// File: doc/BRIEF.md
# Frame-Sync Pulse Generator with Line Offset

This block belongs to the video timing path of an image sensor. It runs a free-running pixel-clock and line counter, and that counter marks the instant a new frame becomes ready for readout. A one-clock strobe reports that instant on `frame_ready_o`.

The block can also drive a frame-timing pulse on a general-purpose output. A host can use it to burst-read a frame and then stay idle until the next pulse. The pulse appears only while the output is set to its sync-pulse mode. It can be moved away from the frame-ready instant by a signed whole number of line periods, from -3 to +3. A negative value makes the pulse lead, so it lands in the last lines of the frame before. A positive value makes it lag. One line period is about 0.5 ms, so the full span is about ±1.5 ms.

The offset register is sampled only at each frame start. A change made in the middle of a frame therefore waits for the next boundary, and every frame gets exactly one pulse.

Top module: `fsync_gen`

## Requirements
- R1: While `rst_ni` is low, `frame_ready_o` and `vsync_o` are both 0.
- R2: `frame_ready_o` is high for exactly one clock every CLKS_PER_LINE*LINES_PER_FRAME clocks. The first high cycle follows the first rising edge after reset is released.
- R3: While `vsync_en_i` is 0, `vsync_o` stays 0 whatever value `offset_i` holds.
- R4: With an offset of 0, `vsync_o` is high in the same cycle as `frame_ready_o`.
- R5: A positive offset k (`offset_i` in 3-bit two's complement, 1..3) moves the pulse k*CLKS_PER_LINE clocks after that frame's `frame_ready_o`.
- R6: A negative offset k (-1..-3) places the pulse at the start of line LINES_PER_FRAME+k of the current frame. It therefore leads the next frame start by |k| line periods.
- R7: The code 3'b100 (-4) is not accepted. It is held as -3, so the pulse behaves exactly as it does for 3'b101.
- R8: `offset_i` is sampled only in the frame-start cycle. A change in mid-frame has no effect until the next frame, and each frame carries exactly one pulse while the mode is enabled.
- R9: When `vsync_en_i` is 0 at a clock edge, `vsync_o` is 0 after that edge.
- R10: Each pulse on `vsync_o` is exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel/timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_en_i | input | 1 | Sync-pulse mode select for the general-purpose output |
| offset_i | input | OFF_W (3) | Signed pulse offset in line periods, two's complement |
| frame_ready_o | output | 1 | One-clock strobe at the internal frame-ready instant |
| vsync_o | output | 1 | Frame-timing pulse, shifted by the latched offset |

## Verification
The bench builds the block with CLKS_PER_LINE=5 and LINES_PER_FRAME=8, which makes a frame 40 clocks long. With that frame length, every offset from -3 to +3 and the wrap of a leading pulse into the end of the frame before fit into a few hundred cycles. The frame-boundary latching of the offset, a disable that falls exactly on a pulse line, and the saturation of -4 are each seen within a single short frame.

// File: rtl/fsync_pkg.sv
`timescale 1ns/1ps
package fsync_pkg;
  // map a signed line offset onto a line index inside one frame
  function automatic int wrap_line(input int off, input int lines);
    return (off < 0) ? off + lines : off;
  endfunction
endpackage

// File: rtl/fsync_line_timer.sv
`timescale 1ns/1ps
module fsync_line_timer #(
  parameter int CLKS_PER_LINE   = 12500,
  parameter int LINES_PER_FRAME = 60,
  localparam int CNT_W  = (CLKS_PER_LINE > 1) ? $clog2(CLKS_PER_LINE) : 1,
  localparam int LINE_W = (LINES_PER_FRAME > 1) ? $clog2(LINES_PER_FRAME) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              line_start_o,
  output logic              frame_start_o,
  output logic [LINE_W-1:0] line_idx_o
);
  localparam logic [CNT_W-1:0]  CLK_LAST  = CNT_W'(CLKS_PER_LINE - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES_PER_FRAME - 1);

  logic [CNT_W-1:0]  clk_cnt_q;
  logic [LINE_W-1:0] line_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_cnt_q  <= '0;
      line_cnt_q <= '0;
    end else if (clk_cnt_q == CLK_LAST) begin
      clk_cnt_q  <= '0;
      line_cnt_q <= (line_cnt_q == LINE_LAST) ? '0 : line_cnt_q + 1'b1;
    end else begin
      clk_cnt_q <= clk_cnt_q + 1'b1;
    end
  end

  assign line_start_o  = (clk_cnt_q == '0);
  assign frame_start_o = line_start_o && (line_cnt_q == '0);
  assign line_idx_o    = line_cnt_q;
endmodule

// File: rtl/fsync_offset_reg.sv
`timescale 1ns/1ps
module fsync_offset_reg #(
  parameter int OFF_W = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    frame_start_i,
  input  logic signed [OFF_W-1:0] offset_i,
  output logic signed [OFF_W-1:0] act_off_o,
  output logic signed [OFF_W-1:0] eff_off_o
);
  localparam logic signed [OFF_W-1:0] MOST_NEG = {1'b1, {(OFF_W-1){1'b0}}};

  logic signed [OFF_W-1:0] sat_off;
  logic signed [OFF_W-1:0] act_q;

  // most negative code has no positive mirror: clamp to keep the span symmetric
  assign sat_off = (offset_i == MOST_NEG) ? MOST_NEG + 1'b1 : offset_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            act_q <= '0;
    else if (frame_start_i) act_q <= sat_off;
  end

  // at the boundary the incoming value already governs the new frame
  assign eff_off_o = frame_start_i ? sat_off : act_q;
  assign act_off_o = act_q;
endmodule

// File: rtl/fsync_pulse_sel.sv
`timescale 1ns/1ps
module fsync_pulse_sel #(
  parameter int OFF_W           = 3,
  parameter int LINES_PER_FRAME = 60,
  localparam int LINE_W = (LINES_PER_FRAME > 1) ? $clog2(LINES_PER_FRAME) : 1
) (
  input  logic                    line_start_i,
  input  logic [LINE_W-1:0]       line_idx_i,
  input  logic signed [OFF_W-1:0] off_i,
  output logic                    hit_o
);
  import fsync_pkg::*;

  logic [LINE_W-1:0] tgt_line;

  always_comb begin
    tgt_line = LINE_W'(wrap_line(int'(off_i), LINES_PER_FRAME));
  end

  assign hit_o = line_start_i && (line_idx_i == tgt_line);
endmodule

// File: rtl/fsync_gen.sv
`timescale 1ns/1ps
module fsync_gen #(
  parameter int CLKS_PER_LINE   = 12500,
  parameter int LINES_PER_FRAME = 60,
  parameter int OFF_W           = 3,
  localparam int LINE_W = (LINES_PER_FRAME > 1) ? $clog2(LINES_PER_FRAME) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vsync_en_i,
  input  logic signed [OFF_W-1:0] offset_i,
  output logic                    frame_ready_o,
  output logic                    vsync_o
);
  logic              line_start, frame_start, hit;
  logic [LINE_W-1:0] line_idx;
  logic signed [OFF_W-1:0] act_off, eff_off;
  logic fr_q, vs_q;

  fsync_line_timer #(
    .CLKS_PER_LINE  (CLKS_PER_LINE),
    .LINES_PER_FRAME(LINES_PER_FRAME)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_start_o (line_start),
    .frame_start_o(frame_start),
    .line_idx_o   (line_idx)
  );

  fsync_offset_reg #(.OFF_W(OFF_W)) u_off (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start),
    .offset_i     (offset_i),
    .act_off_o    (act_off),
    .eff_off_o    (eff_off)
  );

  fsync_pulse_sel #(
    .OFF_W          (OFF_W),
    .LINES_PER_FRAME(LINES_PER_FRAME)
  ) u_sel (
    .line_start_i(line_start),
    .line_idx_i  (line_idx),
    .off_i       (eff_off),
    .hit_o       (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      fr_q <= frame_start;
      vs_q <= vsync_en_i && hit;
    end
  end

  assign frame_ready_o = fr_q;
  assign vsync_o       = vs_q;
endmodule

// File: rtl/fsync_gen_chk.sv
`timescale 1ns/1ps
module fsync_gen_chk #(
  parameter int OFF_W = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    vsync_en_i,
  input logic                    frame_ready_o,
  input logic                    vsync_o,
  input logic signed [OFF_W-1:0] act_off
);
  localparam logic signed [OFF_W-1:0] MOST_NEG = {1'b1, {(OFF_W-1){1'b0}}};

  logic [1:0] vs_cnt;
  logic       seen_fr, en_all, en_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_cnt  <= '0;
      seen_fr <= 1'b0;
      en_all  <= 1'b0;
      en_prev <= 1'b0;
    end else begin
      en_prev <= vsync_en_i;
      if (frame_ready_o) begin
        seen_fr <= 1'b1;
        vs_cnt  <= {1'b0, vsync_o};
        en_all  <= en_prev && vsync_en_i;
      end else begin
        if (vsync_o && vs_cnt != 2'd3) vs_cnt <= vs_cnt + 2'd1;
        en_all <= en_all && vsync_en_i;
      end
    end
  end

  AST_FR_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ready_o |=> !frame_ready_o); // R2
  AST_VS_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |=> !vsync_o); // R10
  AST_VS_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_en_i |=> !vsync_o); // R9
  AST_OFF_CLAMPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_off != MOST_NEG); // R7
  AST_ONE_PER_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_ready_o && seen_fr && en_all) |-> (vs_cnt == 2'd1)); // R8
endmodule

bind fsync_gen fsync_gen_chk #(.OFF_W(OFF_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .vsync_en_i   (vsync_en_i),
  .frame_ready_o(frame_ready_o),
  .vsync_o      (vsync_o),
  .act_off      (act_off)
);

// File: tb/tb_fsync_gen.sv
`timescale 1ns/1ps
module tb_fsync_gen;
  localparam int CPL = 5;
  localparam int LPF = 8;
  localparam int FRM = CPL * LPF;

  typedef struct {
    logic  fr;
    logic  vs;
    string tag;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic vsync_en_i = 1'b0;
  logic signed [2:0] offset_i = '0;
  logic frame_ready_o, vsync_o;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;
  exp_t q[$];

  always #10 clk_i = ~clk_i;

  fsync_gen #(.CLKS_PER_LINE(CPL), .LINES_PER_FRAME(LPF), .OFF_W(3)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .vsync_en_i(vsync_en_i), .offset_i(offset_i),
    .frame_ready_o(frame_ready_o), .vsync_o(vsync_o)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // drive one frame; inputs may change before edge mid_n
  task automatic run_frame(input int off, input logic en, input int mid_n,
                           input int mid_off, input logic mid_en, input string tag);
    int eoff;
    int pline;
    logic en_cur;
    offset_i   = 3'(off);
    vsync_en_i = en;
    eoff  = (off == -4) ? -3 : off;
    pline = (eoff < 0) ? LPF + eoff : eoff;
    en_cur = en;
    for (int n = 0; n < FRM; n++) begin
      exp_t e;
      if (n == mid_n) begin
        offset_i   = 3'(mid_off);
        vsync_en_i = mid_en;
        en_cur     = mid_en;
      end
      e.fr  = (n == 0);
      e.vs  = en_cur && (n % CPL == 0) && (n / CPL == pline);
      e.tag = tag;
      q.push_back(e);
      @(negedge clk_i);
    end
  endtask

  // scoreboard monitor: one expected item per clock edge
  always @(posedge clk_i) begin
    if (mon_on) begin
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check("R2", "frame_ready_o", frame_ready_o, e.fr);
        check(e.tag, "vsync_o", vsync_o, e.vs);
      end
    end
  end

  initial begin
    #(20 * 20000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", "frame_ready_o in reset", frame_ready_o, 1'b0);
    check("R1", "vsync_o in reset", vsync_o, 1'b0);
    rst_ni = 1'b1;
    mon_on = 1'b1;
    run_frame(0, 1'b1, -1, 0, 1'b1, "R4");
    run_frame(2, 1'b1, -1, 0, 1'b1, "R5");
    run_frame(-1, 1'b1, -1, 0, 1'b1, "R6");
    run_frame(-3, 1'b1, -1, 0, 1'b1, "R6");
    run_frame(-4, 1'b1, -1, 0, 1'b1, "R7");
    run_frame(1, 1'b0, -1, 0, 1'b0, "R3");
    run_frame(3, 1'b1, 5, -2, 1'b1, "R8");
    run_frame(2, 1'b1, 2 * CPL, 2, 1'b0, "R9");
    run_frame(0, 1'b1, 1, 3, 1'b1, "R10");
    run_frame(3, 1'b1, -1, 0, 1'b1, "R5");
    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule